// File: doc/BRIEF.md
# SMBus Host Register and Status File

This block is the host-facing register file of a PC-style SMBus controller. Software reaches it through a byte-wide register port with an offset, write data, separate write and read strobes, and read data. The file holds the command byte, the slave address byte, two data bytes, a block-data byte, a control byte and a two-bit auxiliary control field. It presents all of these to a separate transaction engine. Bus signalling and the block buffer belong to that engine, not to this block.

The status byte is cleared by writing ones. The host-busy bit is the exception, because software writes cannot reach it. The engine raises the busy, done and device-error bits through one-cycle set requests. The block sends the engine a single-cycle start pulse and a single-cycle kill pulse. A start issued while interrupts are disabled is not sent at once. Busy goes high, and the launch waits for the next read of the status byte. That read returns the value from before the launch. A level interrupt is raised whenever interrupts are enabled and any status bit other than busy is set.

Top module: `smbh_host_regs`

## Requirements
- R1: Offsets 0x03 (command), 0x04 (slave address), 0x05 (data 0), 0x06 (data 1) and 0x07 (block data) store and return a full byte. Every offset outside 0x00, 0x02, 0x03 to 0x07 and 0x0D reads as zero, and a write to it changes no register.
- R2: In the status byte at offset 0x00, writing a 1 to any of bits 7..1 clears that bit, and writing a 0 leaves it as it is. Bit 1 is done, bit 2 is device error and bit 4 is failed.
- R3: Status bit 0 (host busy) is unchanged by any write to offset 0x00, whatever the data.
- R4: The control byte at offset 0x02 has these fields: bit 0 interrupt enable, bit 1 kill, bits 4:2 protocol, bit 5 last byte, bit 6 start, bit 7 PEC enable. A read returns bits 4:0 with bits 7:5 as zero. Bit 6 is never stored. The protocol, last-byte and PEC fields appear on their engine outputs.
- R5: A control write with bit 1 set sets failed (bit 4), clears busy in the following cycle and emits a kill pulse.
- R6: A control write with bit 6 set and bit 0 set emits a start pulse in the cycle after the write, and busy is not set.
- R7: A control write with bit 6 set and bit 0 clear sets busy and emits no start pulse. The next status read returns the value with busy set. In the following cycle busy is clear and a start pulse is emitted. Later status reads launch nothing.
- R8: The interrupt output is high exactly when control bit 0 is set and any of status bits 7..1 is set.
- R9: The auxiliary byte at offset 0x0D keeps only bits 1:0 (bit 0 PEC, bit 1 block mode) and reads the other bits as zero.
- R10: Start and kill outputs are one cycle wide. A write carrying both kill and start honours both: the start, whether immediate or deferred, and then the kill, which leaves busy clear and failed set.
- R11: An engine set request for busy, done or device error sets the bit in the next cycle. It wins over a write-one-to-clear of the same bit in the same cycle. A done request also clears busy.
- R12: Reset clears status, control, all data bytes and any deferred start. The auxiliary byte resets to 0x02 when the block-mode tie-off parameter is set, and to 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_kill | output | 1 | One-cycle abort pulse to the engine |
| eng_proto | output | 3 | Protocol select field |
| eng_last_byte | output | 1 | Last-byte flag |
| eng_pec_en | output | 1 | PEC enable from control |
| eng_cmd | output | 8 | Command byte |
| eng_slave_addr | output | 8 | Slave address byte with direction bit |
| eng_data0 | output | 8 | Data byte 0 |
| eng_data1 | output | 8 | Data byte 1 |
| eng_block_data | output | 8 | Block data byte |
| eng_aux_pec | output | 1 | Auxiliary PEC flag |
| eng_block_mode | output | 1 | Auxiliary block-buffer mode flag |
| eng_busy_set | input | 1 | Engine request to set busy |
| eng_done_set | input | 1 | Engine request to set done and clear busy |
| eng_err_set | input | 1 | Engine request to set device error |

## Verification
Two events can land on the same cycle. A software write-one-to-clear of a status bit can meet an engine set request for that bit. A kill can also arrive in the same control write as a start. For the first case, the bench raises the engine's device-error request in the same clock as a status write that clears that bit, and then reads the status byte, which must still show the bit set. For the second, control bytes carrying both kill and start are written with interrupts enabled and with them disabled. Each time, the bench checks that both pulses appear as required, that failed is set and that busy is left clear. In the disabled case, a later status read must still release the deferred start.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

   typedef logic [7:0] byte_t;

   // register offsets (software-visible map)
   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_CTRL   = 2;
   localparam int unsigned OFS_CMD    = 3;
   localparam int unsigned OFS_SADDR  = 4;
   localparam int unsigned OFS_DATA0  = 5;
   localparam int unsigned OFS_DATA1  = 6;
   localparam int unsigned OFS_BLOCK  = 7;
   localparam int unsigned OFS_AUX    = 13;
   localparam int unsigned OFS_TOP    = OFS_AUX;

   // plain byte registers, index into the storage vector
   localparam int unsigned N_PLAIN  = 5;
   localparam int unsigned PL_CMD   = 0;
   localparam int unsigned PL_SADDR = 1;
   localparam int unsigned PL_DATA0 = 2;
   localparam int unsigned PL_DATA1 = 3;
   localparam int unsigned PL_BLOCK = 4;

   // status bit positions
   localparam int unsigned ST_BUSY   = 0;
   localparam int unsigned ST_DONE   = 1;
   localparam int unsigned ST_DEVERR = 2;
   localparam int unsigned ST_FAILED = 4;

   // control bit positions
   localparam int unsigned CT_IE    = 0;
   localparam int unsigned CT_KILL  = 1;
   localparam int unsigned CT_LAST  = 5;
   localparam int unsigned CT_START = 6;
   localparam int unsigned CT_PEC   = 7;

   // status bits software writes cannot clear
   localparam byte_t ST_SW_LOCKED  = 8'h01;
   // status bits where a clear request beats a set request
   localparam byte_t ST_CLEAR_WINS = 8'h01;

   function automatic int unsigned plain_offset(input int unsigned idx);
      case (idx)
         PL_CMD:   return OFS_CMD;
         PL_SADDR: return OFS_SADDR;
         PL_DATA0: return OFS_DATA0;
         PL_DATA1: return OFS_DATA1;
         default:  return OFS_BLOCK;
      endcase
   endfunction

endpackage

// File: rtl/smbh_decode.sv
module smbh_decode
   import smbh_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr,
   input  logic               rd,
   output logic               hit_status,
   output logic               hit_ctrl,
   output logic               hit_aux,
   output logic [N_PLAIN-1:0] hit_plain,
   output logic               wr_status,
   output logic               wr_ctrl,
   output logic               wr_aux,
   output logic [N_PLAIN-1:0] wr_plain,
   output logic               rd_status
);

   assign hit_status = (addr == ADDR_W'(OFS_STATUS));
   assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
   assign hit_aux    = (addr == ADDR_W'(OFS_AUX));

   for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
      assign hit_plain[g] = (addr == ADDR_W'(plain_offset(g)));
      assign wr_plain[g]  = wr & hit_plain[g];
   end

   assign wr_status = wr & hit_status;
   assign wr_ctrl   = wr & hit_ctrl;
   assign wr_aux    = wr & hit_aux;
   assign rd_status = rd & hit_status;

endmodule

// File: rtl/smbh_cfgregs.sv
module smbh_cfgregs
   import smbh_pkg::*;
#(
   parameter bit FORCE_BLOCK_MODE = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  byte_t                   wdata,
   input  logic                    wr_ctrl,
   input  logic                    wr_aux,
   input  logic [N_PLAIN-1:0]      wr_plain,
   output logic [N_PLAIN-1:0][7:0] plain_q,
   output logic [4:0]              ctrl_low_q,
   output logic                    ctrl_last_q,
   output logic                    ctrl_pec_q,
   output logic [1:0]              aux_q
);

   // plain byte registers
   for (genvar g = 0; g < N_PLAIN; g++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            plain_q[g] <= '0;
         else if (wr_plain[g])
            plain_q[g] <= wdata;
      end
   end

   // control: start bit is never kept
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_low_q  <= '0;
         ctrl_last_q <= 1'b0;
         ctrl_pec_q  <= 1'b0;
      end else if (wr_ctrl) begin
         ctrl_low_q  <= wdata[4:0];
         ctrl_last_q <= wdata[CT_LAST];
         ctrl_pec_q  <= wdata[CT_PEC];
      end
   end

   // auxiliary control: reset value picked by tie-off
   if (FORCE_BLOCK_MODE) begin : g_aux_forced
      always_ff @(posedge clk) begin
         if (!rst_n)
            aux_q <= 2'b10;
         else if (wr_aux)
            aux_q <= wdata[1:0];
      end
   end else begin : g_aux_plain
      always_ff @(posedge clk) begin
         if (!rst_n)
            aux_q <= 2'b00;
         else if (wr_aux)
            aux_q <= wdata[1:0];
      end
   end

endmodule

// File: rtl/smbh_launch.sv
module smbh_launch (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl,
   input  logic wd_start,
   input  logic wd_ie,
   input  logic wd_kill,
   input  logic rd_status,
   output logic eng_start,
   output logic eng_kill,
   output logic sw_busy_set,
   output logic sw_busy_clr,
   output logic sw_fail_set
);

   logic pending_q;
   logic go_now, go_later, go_deferred, kill_now;

   assign go_now      = wr_ctrl & wd_start & wd_ie;
   assign go_later    = wr_ctrl & wd_start & ~wd_ie;
   assign go_deferred = rd_status & pending_q;
   assign kill_now    = wr_ctrl & wd_kill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         eng_start <= 1'b0;
         eng_kill  <= 1'b0;
      end else begin
         pending_q <= go_later | (pending_q & ~go_deferred & ~go_now);
         eng_start <= go_now | go_deferred;
         eng_kill  <= kill_now;
      end
   end

   // deferred arm raises busy; kill and deferred release lower it
   assign sw_busy_set = go_later;
   assign sw_busy_clr = kill_now | go_deferred;
   assign sw_fail_set = kill_now;

   // R7: deferred start arms and holds back the pulse
   p_defer_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wd_start && !wd_ie) |=> (pending_q && !eng_start));

   // R7: a status read releases an armed start
   p_deferred_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && pending_q && !wr_ctrl) |=> eng_start);

   // R6: every start pulse has a cause one cycle earlier
   p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> $past((wr_ctrl && wd_start && wd_ie) || (rd_status && pending_q)));

   // R5: kill pulse only follows a kill write
   p_kill_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_kill |-> $past(wr_ctrl && wd_kill));

endmodule

// File: rtl/smbh_status.sv
module smbh_status
   import smbh_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_status,
   input  byte_t wdata,
   input  logic  sw_busy_set,
   input  logic  sw_busy_clr,
   input  logic  sw_fail_set,
   input  logic  eng_busy_set,
   input  logic  eng_done_set,
   input  logic  eng_err_set,
   output byte_t stat_q
);

   byte_t set_v, clr_v, nxt;

   always_comb begin
      set_v            = '0;
      set_v[ST_BUSY]   = sw_busy_set | eng_busy_set;
      set_v[ST_DONE]   = eng_done_set;
      set_v[ST_DEVERR] = eng_err_set;
      set_v[ST_FAILED] = sw_fail_set;
      clr_v            = wr_status ? (wdata & ~ST_SW_LOCKED) : '0;
      clr_v[ST_BUSY]   = clr_v[ST_BUSY] | sw_busy_clr | eng_done_set;
   end

   for (genvar g = 0; g < 8; g++) begin : g_bit
      if (ST_CLEAR_WINS[g]) begin : g_clr_wins
         assign nxt[g] = (stat_q[g] | set_v[g]) & ~clr_v[g];
      end else begin : g_set_wins
         assign nxt[g] = (stat_q[g] & ~clr_v[g]) | set_v[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         stat_q <= '0;
      else
         stat_q <= nxt;
   end

   // R3: software cannot drop busy
   p_busy_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && stat_q[ST_BUSY] && !sw_busy_clr && !eng_done_set) |=> stat_q[ST_BUSY]);

   // R2: write-one clears device error when the engine is quiet
   p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && wdata[ST_DEVERR] && !eng_err_set) |=> !stat_q[ST_DEVERR]);

   // R11: engine set beats a simultaneous clear
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err_set |=> stat_q[ST_DEVERR]);

   // R5: kill leaves failed set and busy clear
   p_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_fail_set |=> (stat_q[ST_FAILED] && !stat_q[ST_BUSY]));

endmodule

// File: rtl/smbh_host_regs.sv
module smbh_host_regs
   import smbh_pkg::*;
#(
   parameter int unsigned ADDR_W           = 6,
   parameter bit          FORCE_BLOCK_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              eng_start,
   output logic              eng_kill,
   output logic [2:0]        eng_proto,
   output logic              eng_last_byte,
   output logic              eng_pec_en,
   output logic [7:0]        eng_cmd,
   output logic [7:0]        eng_slave_addr,
   output logic [7:0]        eng_data0,
   output logic [7:0]        eng_data1,
   output logic [7:0]        eng_block_data,
   output logic              eng_aux_pec,
   output logic              eng_block_mode,
   input  logic              eng_busy_set,
   input  logic              eng_done_set,
   input  logic              eng_err_set
);

   localparam int unsigned MIN_ADDR_W = $clog2(OFS_TOP + 1);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("smbh_host_regs: ADDR_W too narrow for the register map");
   end

   logic               hit_status, hit_ctrl, hit_aux, hit_any;
   logic [N_PLAIN-1:0] hit_plain, wr_plain;
   logic               wr_status, wr_ctrl, wr_aux, rd_status;
   logic [N_PLAIN-1:0][7:0] plain_q;
   logic [4:0]         ctrl_low_q;
   logic               ctrl_last_q, ctrl_pec_q;
   logic [1:0]         aux_q;
   logic               sw_busy_set, sw_busy_clr, sw_fail_set;
   byte_t              stat_q, rd_mux;

   smbh_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr      (reg_addr),
      .wr        (reg_wr),
      .rd        (reg_rd),
      .hit_status(hit_status),
      .hit_ctrl  (hit_ctrl),
      .hit_aux   (hit_aux),
      .hit_plain (hit_plain),
      .wr_status (wr_status),
      .wr_ctrl   (wr_ctrl),
      .wr_aux    (wr_aux),
      .wr_plain  (wr_plain),
      .rd_status (rd_status)
   );

   smbh_cfgregs #(.FORCE_BLOCK_MODE(FORCE_BLOCK_MODE)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata      (reg_wdata),
      .wr_ctrl    (wr_ctrl),
      .wr_aux     (wr_aux),
      .wr_plain   (wr_plain),
      .plain_q    (plain_q),
      .ctrl_low_q (ctrl_low_q),
      .ctrl_last_q(ctrl_last_q),
      .ctrl_pec_q (ctrl_pec_q),
      .aux_q      (aux_q)
   );

   smbh_launch u_launch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl),
      .wd_start   (reg_wdata[CT_START]),
      .wd_ie      (reg_wdata[CT_IE]),
      .wd_kill    (reg_wdata[CT_KILL]),
      .rd_status  (rd_status),
      .eng_start  (eng_start),
      .eng_kill   (eng_kill),
      .sw_busy_set(sw_busy_set),
      .sw_busy_clr(sw_busy_clr),
      .sw_fail_set(sw_fail_set)
   );

   smbh_status u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_status   (wr_status),
      .wdata       (reg_wdata),
      .sw_busy_set (sw_busy_set),
      .sw_busy_clr (sw_busy_clr),
      .sw_fail_set (sw_fail_set),
      .eng_busy_set(eng_busy_set),
      .eng_done_set(eng_done_set),
      .eng_err_set (eng_err_set),
      .stat_q      (stat_q)
   );

   // read path
   assign hit_any = hit_status | hit_ctrl | hit_aux | (|hit_plain);

   always_comb begin
      rd_mux = '0;
      if (hit_status) rd_mux = stat_q;
      if (hit_ctrl)   rd_mux = {3'b000, ctrl_low_q};
      if (hit_aux)    rd_mux = {6'b000000, aux_q};
      for (int i = 0; i < N_PLAIN; i++) begin
         if (hit_plain[i]) rd_mux = plain_q[i];
      end
   end

   assign reg_rdata = reg_rd ? rd_mux : '0;

   // interrupt: any non-busy status bit with enable
   assign irq = ctrl_low_q[CT_IE] & (|(stat_q & ~byte_t'(1 << ST_BUSY)));

   // engine view
   assign eng_proto      = ctrl_low_q[4:2];
   assign eng_last_byte  = ctrl_last_q;
   assign eng_pec_en     = ctrl_pec_q;
   assign eng_cmd        = plain_q[PL_CMD];
   assign eng_slave_addr = plain_q[PL_SADDR];
   assign eng_data0      = plain_q[PL_DATA0];
   assign eng_data1      = plain_q[PL_DATA1];
   assign eng_block_data = plain_q[PL_BLOCK];
   assign eng_aux_pec    = aux_q[0];
   assign eng_block_mode = aux_q[1];

   // R8: a done request under enable raises the interrupt
   p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done_set && ctrl_low_q[CT_IE] && !wr_ctrl) |=> irq);

   // R4: control readback never shows bits 7:5
   p_ctrl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && hit_ctrl) |-> (reg_rdata[7:5] == 3'b000));

   // R1: unmapped offsets read as zero
   p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !hit_any) |-> (reg_rdata == 8'h00));

endmodule

// File: tb/smbh_host_regs_test.sv
module smbh_host_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic       irq, eng_start, eng_kill;
   logic [2:0] eng_proto;
   logic       eng_last_byte, eng_pec_en;
   logic [7:0] eng_cmd, eng_slave_addr, eng_data0, eng_data1, eng_block_data;
   logic       eng_aux_pec, eng_block_mode;
   logic       eng_busy_set = 1'b0;
   logic       eng_done_set = 1'b0;
   logic       eng_err_set  = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   always #(10ns) clk = ~clk;

   smbh_host_regs #(.ADDR_W(6), .FORCE_BLOCK_MODE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq),
      .eng_start(eng_start), .eng_kill(eng_kill), .eng_proto(eng_proto),
      .eng_last_byte(eng_last_byte), .eng_pec_en(eng_pec_en), .eng_cmd(eng_cmd),
      .eng_slave_addr(eng_slave_addr), .eng_data0(eng_data0), .eng_data1(eng_data1),
      .eng_block_data(eng_block_data), .eng_aux_pec(eng_aux_pec),
      .eng_block_mode(eng_block_mode), .eng_busy_set(eng_busy_set),
      .eng_done_set(eng_done_set), .eng_err_set(eng_err_set)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: samples mid-way between negedge and posedge
   always @(negedge clk) begin
      #(5ns);
      if (reg_rd) begin
         if (exp_q.size() == 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 unexpected read actual=0x%02h expected=none", reg_rdata);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, reg_rdata, e.val);
         end
      end
   end

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      exp_q.push_back('{e, tag});
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic eng(input logic b, input logic d, input logic e);
      @(negedge clk);
      eng_busy_set = b; eng_done_set = d; eng_err_set = e;
      @(negedge clk);
      eng_busy_set = 1'b0; eng_done_set = 1'b0; eng_err_set = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      rd(6'h00, 8'h00, "R12 status after reset");
      rd(6'h0D, 8'h02, "R12 aux forced block mode");
      rd(6'h02, 8'h00, "R12 control after reset");
      rd(6'h05, 8'h00, "R12 data0 after reset");
      #(1ns);
      chk("R12 irq after reset", {7'd0, irq}, 8'h00);
      chk("R12 start idle", {7'd0, eng_start}, 8'h00);

      // R1 plain registers
      wr(6'h03, 8'hA5); wr(6'h04, 8'h5B); wr(6'h05, 8'h12);
      wr(6'h06, 8'h34); wr(6'h07, 8'h77);
      rd(6'h03, 8'hA5, "R1 command");
      rd(6'h04, 8'h5B, "R1 slave address");
      rd(6'h05, 8'h12, "R1 data0");
      rd(6'h06, 8'h34, "R1 data1");
      rd(6'h07, 8'h77, "R1 block data");
      chk("R1 command port", eng_cmd, 8'hA5);
      chk("R1 data1 port", eng_data1, 8'h34);

      // R1 unmapped
      wr(6'h08, 8'hEE);
      rd(6'h08, 8'h00, "R1 unmapped 0x08");
      rd(6'h01, 8'h00, "R1 unmapped 0x01");
      rd(6'h3F, 8'h00, "R1 unmapped 0x3F");
      rd(6'h03, 8'hA5, "R1 command untouched by unmapped write");

      // R9 aux mask
      wr(6'h0D, 8'hFF);
      rd(6'h0D, 8'h03, "R9 aux masked");
      chk("R9 block mode port", {7'd0, eng_block_mode}, 8'h01);
      chk("R9 aux pec port", {7'd0, eng_aux_pec}, 8'h01);
      wr(6'h0D, 8'h00);
      rd(6'h0D, 8'h00, "R9 aux cleared");

      // R4 control readback
      wr(6'h02, 8'hBD);
      #(1ns);
      chk("R4 no start without bit6", {7'd0, eng_start}, 8'h00);
      rd(6'h02, 8'h1D, "R4 control readback");
      chk("R4 protocol port", {5'd0, eng_proto}, 8'h07);
      chk("R4 last/pec ports", {6'd0, eng_last_byte, eng_pec_en}, 8'h03);
      chk("R8 irq low with clean status", {7'd0, irq}, 8'h00);

      // R6 immediate start, R10 pulse width
      wr(6'h02, 8'h41);
      #(1ns);
      chk("R6 immediate start pulse", {6'd0, eng_kill, eng_start}, 8'h01);
      @(negedge clk); #(1ns);
      chk("R10 start pulse one cycle", {7'd0, eng_start}, 8'h00);
      rd(6'h00, 8'h00, "R6 busy not set by immediate start");
      rd(6'h02, 8'h01, "R4 start bit not stored");

      // R11 engine requests, R8 irq
      eng(1'b1, 1'b0, 1'b0);
      rd(6'h00, 8'h01, "R11 engine busy set");
      chk("R8 busy alone gives no irq", {7'd0, irq}, 8'h00);
      eng(1'b0, 1'b1, 1'b0);
      rd(6'h00, 8'h02, "R11 done sets done and clears busy");
      chk("R8 irq on done", {7'd0, irq}, 8'h01);

      // R2 write-one-to-clear
      wr(6'h00, 8'h02);
      rd(6'h00, 8'h00, "R2 done cleared");
      #(1ns);
      chk("R8 irq drops after clear", {7'd0, irq}, 8'h00);

      // R3 busy immune
      eng(1'b1, 1'b0, 1'b0);
      wr(6'h00, 8'hFF);
      rd(6'h00, 8'h01, "R3 busy survives write of ones");
      eng(1'b0, 1'b1, 1'b0);
      wr(6'h00, 8'h02);
      rd(6'h00, 8'h00, "R2 status clean");

      // R7 deferred start (control bit0 clear)
      wr(6'h02, 8'h40);
      #(1ns);
      chk("R7 no pulse on deferred write", {7'd0, eng_start}, 8'h00);
      @(negedge clk); #(1ns);
      chk("R7 still held", {7'd0, eng_start}, 8'h00);
      rd(6'h00, 8'h01, "R7 status read returns busy");
      #(1ns);
      chk("R7 start after status read", {7'd0, eng_start}, 8'h01);
      rd(6'h00, 8'h00, "R7 busy cleared after release");
      #(1ns);
      chk("R7 no second launch", {7'd0, eng_start}, 8'h00);

      // R5 kill
      wr(6'h02, 8'h01);
      eng(1'b1, 1'b0, 1'b0);
      wr(6'h02, 8'h03);
      #(1ns);
      chk("R5 kill pulse", {6'd0, eng_kill, eng_start}, 8'h02);
      @(negedge clk); #(1ns);
      chk("R10 kill pulse one cycle", {7'd0, eng_kill}, 8'h00);
      rd(6'h00, 8'h10, "R5 failed set busy cleared");
      chk("R8 irq on failed", {7'd0, irq}, 8'h01);
      wr(6'h00, 8'h10);
      rd(6'h00, 8'h00, "R2 failed cleared");

      // R10 kill with immediate start
      wr(6'h02, 8'h43);
      #(1ns);
      chk("R10 kill+start immediate", {6'd0, eng_kill, eng_start}, 8'h03);
      rd(6'h00, 8'h10, "R10 failed after kill+start");
      wr(6'h00, 8'h10);

      // R10 kill with deferred start
      wr(6'h02, 8'h42);
      #(1ns);
      chk("R10 kill+deferred pulses", {6'd0, eng_kill, eng_start}, 8'h02);
      rd(6'h00, 8'h10, "R10 busy cleared by kill after defer");
      #(1ns);
      chk("R10 deferred start still released", {7'd0, eng_start}, 8'h01);
      wr(6'h00, 8'h10);
      rd(6'h00, 8'h00, "R2 status clean again");

      // R11 set beats simultaneous clear
      @(negedge clk);
      reg_addr = 6'h00; reg_wdata = 8'h04; reg_wr = 1'b1; eng_err_set = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; eng_err_set = 1'b0;
      rd(6'h00, 8'h04, "R11 error set wins over clear");
      chk("R8 irq low with enable off", {7'd0, irq}, 8'h00);
      wr(6'h02, 8'h01);
      #(1ns);
      chk("R8 irq with enable on", {7'd0, irq}, 8'h01);
      wr(6'h00, 8'h04);
      rd(6'h00, 8'h00, "R2 error cleared");

      // R12 reset drops deferred start and data
      wr(6'h02, 8'h00);
      wr(6'h05, 8'h55);
      wr(6'h02, 8'h40);
      do_reset();
      rd(6'h00, 8'h00, "R12 status after second reset");
      #(1ns);
      chk("R12 pending start discarded", {7'd0, eng_start}, 8'h00);
      rd(6'h05, 8'h00, "R12 data0 cleared");
      rd(6'h0D, 8'h02, "R12 aux restored");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 scoreboard left actual=%0d expected=0", exp_q.size());
      end
      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         report();
         $finish;
      end
   end

endmodule